// File: doc/BRIEF.md
# Row-Strobe-Only Refresh Scheduler

This block produces all refresh traffic for a dynamic memory whose array has 128 rows. It owns a 7-bit refresh row pointer and an interval timer. The timer period is derived from a clock-frequency parameter so that the 128 rows are spread evenly over each 2 ms retention window. When the block needs a refresh it raises a request to the memory controller. Once the controller grants the bus, the block runs a row-strobe-only cycle. The refresh row is driven on the multiplexed address pins and the active-low row strobe is held low for a parameterised number of clocks. The active-low column strobe stays high, so no data moves. The controller then reports that the cycle is finished.

Out of reset the block performs a warm-up burst of eight refresh cycles back to back, and only then reports the memory ready. After that it switches to distributed refresh. Timer expiries that arrive before the controller has served earlier ones are held in a small pending counter. If that counter saturates and yet another expiry arrives, an overrun error is flagged. A sweep monitor separately flags a retention error when a full pass over all rows takes longer than the retention window.

Top module: `refsched_top`

## Requirements
- R1: After reset, ready, both error flags and the pending count are zero. The row pointer and address output are 0. Both strobes are high (inactive). The request is high because the warm-up burst is owed.
- R2: Ready rises in the cycle after the controller reports the eighth completed warm-up cycle, and not before.
- R3: Once ready is high it stays high until the next reset.
- R4: A grant sampled while the request is high drives the row strobe low for exactly PULSE_CYC (default 3) cycles, starting in the next cycle. During that time the address output carries the refresh row. The column strobe output is high at all times.
- R5: The row pointer advances by one only when the done input is sampled high after the strobe pulse has ended. It wraps from 127 to 0. A grant while the request is low, or a done outside that waiting phase, changes nothing.
- R6: After ready, a timer expiry occurs every floor(CLK_HZ × WINDOW_US / 10^6 / 128) cycles. The first expiry comes that many cycles after ready rises. Before ready the timer is stopped.
- R7: Each expiry adds one to the pending count, and each completed periodic refresh removes one. When both happen in the same cycle the count is unchanged. After ready, the request is high exactly while the count is non-zero and no cycle is in progress.
- R8: An expiry that finds the pending count at its maximum (2^PEND_W − 1 = 3) while no refresh completes in that cycle sets a sticky overrun error. The count stays at its maximum.
- R9: If no 127→0 wrap of the row pointer occurs within WINDOW_US worth of cycles after the previous wrap, a sticky retention error is set. The flag rises exactly that many cycles after the wrap edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_o | output | 1 | Refresh request to the controller |
| gnt_i | input | 1 | Controller grant, sampled while req_o is high |
| done_i | input | 1 | Controller reports the refresh cycle finished |
| row_addr_o | output | 7 | Refresh row on the multiplexed address pins |
| row_strobe_n_o | output | 1 | Active-low row strobe |
| col_strobe_n_o | output | 1 | Active-low column strobe, held inactive |
| ready_o | output | 1 | Warm-up complete, memory usable |
| overrun_err_o | output | 1 | Sticky: a timer expiry was lost |
| retention_err_o | output | 1 | Sticky: a full row sweep exceeded the window |

## Verification
The delicate collision is a timer expiry landing in the same cycle as a completed periodic refresh. There the pending count must take the increment and the decrement together and keep its value. The bench lets two expiries accumulate, grants one refresh, and holds done back so that it is sampled exactly on the third expiry edge. It then checks that two more refreshes are still owed and that the request drops after them. Saturation of the count is provoked separately by withholding grants across four expiries, and the overrun flag is judged on the exact edge of the fourth expiry.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_WAIT   = 2'd2
    } phase_e;

    // Cycles in a window of win_us microseconds at clk_hz.
    function automatic longint unsigned window_cycles(longint unsigned clk_hz,
                                                      longint unsigned win_us);
        return (clk_hz * win_us) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int unsigned INTERVAL = 781
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (en_i) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R6

    AST_TICK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> en_i); // R6

endmodule

// File: rtl/refsched_pend.sv
module refsched_pend #(
    parameter int unsigned PEND_W = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    output logic nonzero_o,
    output logic ovf_o
);
    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
        logic              ovf;
    } pend_t;

    pend_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case ({inc_i, dec_i})
            2'b10: begin
                if (s_q.cnt == MAXV) s_d.ovf = 1'b1;
                else                 s_d.cnt = s_q.cnt + 1'b1;
            end
            2'b01: begin
                if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign nonzero_o = (s_q.cnt != '0);
    assign ovf_o     = s_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ovf |=> s_q.ovf); // R8

    AST_PEND_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt == MAXV && !dec_i) |=> (s_q.cnt == MAXV)); // R8

    AST_PEND_BALANCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && dec_i) |=> $stable(s_q.cnt)); // R7

endmodule

// File: rtl/refsched_window_mon.sv
module refsched_window_mon #(
    parameter int unsigned WIN_CYC = 100000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic wrap_i,
    output logic err_o
);
    localparam int unsigned AGE_W = $clog2(WIN_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(WIN_CYC - 1);

    typedef struct packed {
        logic [AGE_W-1:0] age;
        logic             err;
    } mon_t;

    mon_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap_i) begin
            s_d.age = '0;
        end else if (en_i && !s_q.err) begin
            if (s_q.age == AGE_LIM) s_d.err = 1'b1;
            else                    s_d.age = s_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign err_o = s_q.err;

    AST_RET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.err |=> s_q.err); // R9

    AST_RET_NOT_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && !s_q.err) |=> !s_q.err); // R9

endmodule

// File: rtl/refsched_cycle_fsm.sv
module refsched_cycle_fsm
    import refsched_pkg::*;
#(
    parameter int unsigned ROW_W     = 7,
    parameter int unsigned INIT_CYC  = 8,
    parameter int unsigned PULSE_CYC = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             owed_i,
    input  logic             gnt_i,
    input  logic             done_i,
    output logic             req_o,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             row_strobe_n_o,
    output logic             ready_o,
    output logic             cmpl_periodic_o,
    output logic             wrap_o
);
    localparam int unsigned PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam int unsigned IW = $clog2(INIT_CYC + 1);
    localparam logic [PW-1:0]    PULSE_LAST = PW'(PULSE_CYC - 1);
    localparam logic [IW-1:0]    INIT_LAST  = IW'(INIT_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_TOP    = {ROW_W{1'b1}};

    typedef struct packed {
        phase_e           ph;
        logic [PW-1:0]    pcnt;
        logic [ROW_W-1:0] row;
        logic [IW-1:0]    icnt;
        logic             ready;
    } fsm_t;

    fsm_t s_d, s_q;
    logic finishing;

    assign req_o     = (s_q.ph == PH_IDLE) && (s_q.ready ? owed_i : 1'b1);
    assign finishing = (s_q.ph == PH_WAIT) && done_i;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_o && gnt_i) begin
                    s_d.ph   = PH_STROBE;
                    s_d.pcnt = PULSE_LAST;
                end
            end
            PH_STROBE: begin
                if (s_q.pcnt == '0) s_d.ph = PH_WAIT;
                else                s_d.pcnt = s_q.pcnt - 1'b1;
            end
            PH_WAIT: begin
                if (done_i) begin
                    s_d.ph  = PH_IDLE;
                    s_d.row = s_q.row + 1'b1;
                    if (!s_q.ready) begin
                        s_d.icnt = s_q.icnt + 1'b1;
                        if (s_q.icnt == INIT_LAST) s_d.ready = 1'b1;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign row_addr_o      = s_q.row;
    assign row_strobe_n_o  = (s_q.ph != PH_STROBE);
    assign ready_o         = s_q.ready;
    assign cmpl_periodic_o = finishing && s_q.ready;
    assign wrap_o          = finishing && (s_q.row == ROW_TOP);

    AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ready |=> s_q.ready); // R3

    AST_READY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.ready) |-> $past(done_i)); // R2

    AST_STROBE_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(row_strobe_n_o) |-> $past(req_o && gnt_i)); // R4

    AST_ROW_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.row != $past(s_q.row)) |-> $past(s_q.ph == PH_WAIT && done_i)); // R5

    AST_ADDR_STABLE_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!row_strobe_n_o && $past(!row_strobe_n_o)) |-> $stable(row_addr_o)); // R4

endmodule

// File: rtl/refsched_top.sv
module refsched_top
    import refsched_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned WINDOW_US = 2000,
    parameter int unsigned ROW_W     = 7,
    parameter int unsigned INIT_CYC  = 8,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned PEND_W    = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic             req_o,
    input  logic             gnt_i,
    input  logic             done_i,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             row_strobe_n_o,
    output logic             col_strobe_n_o,
    output logic             ready_o,
    output logic             overrun_err_o,
    output logic             retention_err_o
);
    localparam int unsigned ROWS     = 1 << ROW_W;
    localparam int unsigned WIN_CYC  = 32'(window_cycles(64'(CLK_HZ), 64'(WINDOW_US)));
    localparam int unsigned INTERVAL = WIN_CYC / ROWS;

    logic tick, owed, cmpl, wrap;

    refsched_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (ready_o),
        .tick_o (tick)
    );

    refsched_pend #(.PEND_W(PEND_W)) u_pend (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (tick),
        .dec_i     (cmpl),
        .nonzero_o (owed),
        .ovf_o     (overrun_err_o)
    );

    refsched_cycle_fsm #(
        .ROW_W     (ROW_W),
        .INIT_CYC  (INIT_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_fsm (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .owed_i          (owed),
        .gnt_i           (gnt_i),
        .done_i          (done_i),
        .req_o           (req_o),
        .row_addr_o      (row_addr_o),
        .row_strobe_n_o  (row_strobe_n_o),
        .ready_o         (ready_o),
        .cmpl_periodic_o (cmpl),
        .wrap_o          (wrap)
    );

    refsched_window_mon #(.WIN_CYC(WIN_CYC)) u_win (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (ready_o),
        .wrap_i (wrap),
        .err_o  (retention_err_o)
    );

    assign col_strobe_n_o = 1'b1;

    AST_NO_REQ_WHEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !owed) |-> !req_o); // R7

    AST_TICK_RAISES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && row_strobe_n_o && req_o == 1'b0 && !cmpl && ready_o) |=> (owed)); // R7

endmodule

// File: tb/refsched_top_tb_top.sv
module refsched_top_tb_top;
    localparam int unsigned TB_CLK_HZ = 1_280_000;
    localparam int WIN  = 2560;
    localparam int IVL  = 20;
    localparam int PULS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic done = 1'b0;
    logic req, rs_n, cs_n, ready, ovf, ret;
    logic [6:0] addr;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] exp_row = '0;
    int e_cyc = 0;
    int w_cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refsched_top #(
        .CLK_HZ    (TB_CLK_HZ),
        .WINDOW_US (2000),
        .ROW_W     (7),
        .INIT_CYC  (8),
        .PULSE_CYC (PULS),
        .PEND_W    (2)
    ) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .req_o           (req),
        .gnt_i           (gnt),
        .done_i          (done),
        .row_addr_o      (addr),
        .row_strobe_n_o  (rs_n),
        .col_strobe_n_o  (cs_n),
        .ready_o         (ready),
        .overrun_err_o   (ovf),
        .retention_err_o (ret)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One complete refresh cycle served promptly; checks R4 and R5 on the way.
    task automatic serve();
        int guard = 0;
        while (!req && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk("R7 request raised", int'(req), 1);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        for (int i = 0; i < PULS; i++) begin
            chk("R4 row strobe low", int'(rs_n), 0);
            chk("R4 column strobe high", int'(cs_n), 1);
            chk("R4 refresh row on address", int'(addr), int'(exp_row));
            @(negedge clk);
        end
        chk("R4 strobe pulse ends", int'(rs_n), 1);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        exp_row = exp_row + 7'd1;
        chk("R5 row pointer advanced", int'(addr), int'(exp_row));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        gnt = 1'b0;
        done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_row = '0;
    endtask

    task automatic t_reset_state();
        chk("R1 ready low", int'(ready), 0);
        chk("R1 overrun clear", int'(ovf), 0);
        chk("R1 retention clear", int'(ret), 0);
        chk("R1 row strobe high", int'(rs_n), 1);
        chk("R1 column strobe high", int'(cs_n), 1);
        chk("R1 address zero", int'(addr), 0);
        chk("R1 warm-up request", int'(req), 1);
    endtask

    task automatic t_warmup();
        for (int k = 0; k < 8; k++) begin
            chk("R2 not ready during warm-up", int'(ready), 0);
            serve();
        end
        chk("R2 ready after eighth cycle", int'(ready), 1);
        e_cyc = cyc;
        chk("R7 no request with nothing owed", int'(req), 0);
    endtask

    task automatic t_ignored();
        wait_until(e_cyc + 2);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R5 stray grant gives no strobe", int'(rs_n), 1);
            @(negedge clk);
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R5 stray done leaves row", int'(addr), int'(exp_row));
    endtask

    task automatic t_interval();
        wait_until(e_cyc + IVL - 1);
        chk("R6 no expiry before interval", int'(req), 0);
        wait_until(e_cyc + IVL);
        chk("R6 expiry after interval", int'(req), 1);
    endtask

    task automatic t_collide();
        int k2 = e_cyc + 2 * IVL;
        int k3 = e_cyc + 3 * IVL;
        wait_until(k2);
        chk("R7 two owed", int'(req), 1);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        wait_until(k3 - 1);
        chk("R4 waiting phase", int'(rs_n), 1);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        exp_row = exp_row + 7'd1;
        chk("R7 collision keeps request", int'(req), 1);
        serve();
        serve();
        chk("R7 collision count was two", int'(req), 0);
        wait_until(e_cyc + 4 * IVL);
        chk("R7 next expiry owed", int'(req), 1);
    endtask

    task automatic t_sweep();
        logic wrapped = 1'b0;
        while (!wrapped) begin
            if (exp_row == 7'd127) chk("R5 top row served", int'(addr), 127);
            serve();
            if (exp_row == 7'd0) wrapped = 1'b1;
        end
        w_cyc = cyc;
        chk("R5 wrapped to zero", int'(addr), 0);
        chk("R9 no retention error", int'(ret), 0);
        chk("R8 no overrun", int'(ovf), 0);
    endtask

    task automatic t_starve();
        int n0 = (w_cyc - e_cyc) / IVL + 1;
        int k4 = e_cyc + IVL * (n0 + 3);
        wait_until(k4 - 1);
        chk("R8 three owed no overrun", int'(ovf), 0);
        wait_until(k4);
        chk("R8 fourth expiry overruns", int'(ovf), 1);
        wait_until(k4 + IVL);
        chk("R8 overrun sticky", int'(ovf), 1);
        wait_until(w_cyc + WIN - 1);
        chk("R9 not yet late", int'(ret), 0);
        wait_until(w_cyc + WIN);
        chk("R9 sweep late", int'(ret), 1);
        wait_until(w_cyc + WIN + 5);
        chk("R9 retention sticky", int'(ret), 1);
        chk("R3 ready still high", int'(ready), 1);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_warmup();
        t_ignored();
        t_interval();
        t_collide();
        t_sweep();
        t_starve();
        do_reset();
        t_reset_state();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

endmodule